// File: doc/BRIEF.md
# Sequential-Access I2C Configuration Register Slave

This block is an I2C target that keeps a small bank of 8-bit configuration registers and offers them to a bus controller through a simplified block-transfer protocol. Both bus lines are oversampled by a fast system clock. The block drives the data line only through an open-drain pull-low enable, and it presents the full register contents as a flat vector so that neighbouring logic can decode individual fields.

A write transfer starts with the 7-bit target address and the write bit. Two header bytes follow, a command byte and a count byte. The block acknowledges both and discards their values. Every byte after the header loads the next register, starting at register 0. A read transfer never takes a register index. The block first sends a count byte equal to the number of registers, then sends every register from index 0 upward until the controller declines a byte. Each START rewinds the register pointer to the beginning.

Top module: `cfgi2c_slave_top`

## Requirements
- R1: An address byte of 0xD2 (write) or 0xD3 (read) is acknowledged by pulling SDA low during the ninth clock. Any other address gets no acknowledge, and the block leaves SDA alone and ignores every later byte until the next START.
- R2: In a write, the two bytes after the address (command, then count) are each acknowledged and change no register.
- R3: The third and later bytes of a write are each acknowledged and stored in order into register 0, then 1, and so on up to register 6. Register k appears on regs_o bits [8k+7:8k].
- R4: Data bytes beyond register 6 are acknowledged and discarded. Register 7 is read-only and keeps its reset value.
- R5: A STOP after any complete byte ends the write. Registers written before the STOP keep their new values, and registers not reached keep their old values.
- R6: A read first returns a count byte of 0x08, then registers 0 through 7 in index order, MSB first, for as long as the controller acknowledges.
- R7: When the controller answers a read byte with NACK (SDA high on the ninth clock), the block releases SDA and drives nothing more until STOP or START.
- R8: Every START, including a repeated START with no STOP before it, resets the byte position. The next write data byte goes to register 0 again, and the next read begins again with the count byte.
- R9: After reset, registers 1 and 2 hold 0xFF, all other registers hold 0x00, and SDA is released.
- R10: The SDA pull-low enable is only asserted while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8 times the bus bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired value) |
| sda_pull_o | output | 1 | 1 = drive SDA low, 0 = release SDA |
| regs_o | output | 64 | Register contents, register k in bits [8k+7:8k] |

## Verification
The hardest case to reach is a controller NACK in the middle of a read, followed by further clocking before the STOP. If the block kept shifting out data after the NACK, the error would show only as extra low bits on a line that the controller is no longer sampling. The bench stops a read with a NACK straight after the count byte, clocks a full byte with SDA released, and checks that the wired line reads back as 0xFF. It then sends a repeated START inside a write and checks that the second data byte lands in register 0 again.

// File: rtl/cfgi2c_pkg.sv
package cfgi2c_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_RX_ACK,
      ST_TX,
      ST_TX_ACK,
      ST_TX_NEXT,
      ST_WAIT
   } slv_state_e;

   localparam int unsigned HDR_BYTES = 3;  // address + command + count precede write data
   localparam int unsigned RD_SKIP   = 2;  // address + count precede read data
endpackage

// File: rtl/cfgi2c_line_sync.sv
module cfgi2c_line_sync #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_lvl,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("cfgi2c_line_sync: SYNC_STAGES must be at least 2");
   end

   logic [1:0] raw;
   logic [1:0] lvl;
   logic [1:0] prv;

   assign raw = {sda_i, scl_i};

   for (genvar g = 0; g < 2; g++) begin : g_line
      logic [SYNC_STAGES:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '1;
         else        chain <= {chain[SYNC_STAGES-1:0], raw[g]};
      end
      assign lvl[g] = chain[SYNC_STAGES-1];
      assign prv[g] = chain[SYNC_STAGES];
   end

   assign scl_lvl   = lvl[0];
   assign sda_lvl   = lvl[1];
   assign scl_rise  = lvl[0] & ~prv[0];
   assign scl_fall  = ~lvl[0] & prv[0];
   assign start_det = lvl[0] & prv[0] & prv[1] & ~lvl[1];
   assign stop_det  = lvl[0] & prv[0] & ~prv[1] & lvl[1];
endmodule

// File: rtl/cfgi2c_reg_bank.sv
module cfgi2c_reg_bank #(
   parameter int unsigned          NUM_REGS = 8,
   parameter int unsigned          WR_LAST  = 6,
   parameter int unsigned          IDX_W    = 3,
   parameter logic [NUM_REGS*8-1:0] DEFAULTS = '0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [IDX_W-1:0]      wr_idx,
   input  logic [7:0]            wr_data,
   input  logic [IDX_W-1:0]      rd_idx,
   output logic [7:0]            rd_data,
   output logic [NUM_REGS*8-1:0] regs_flat
);
   if (WR_LAST >= NUM_REGS) begin : g_bad_last
      $error("cfgi2c_reg_bank: WR_LAST must be below NUM_REGS");
   end

   logic [7:0] regs_a [NUM_REGS];

   for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
      if (k <= WR_LAST) begin : g_rw
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                               regs_a[k] <= DEFAULTS[8*k +: 8];
            else if (wr_en && wr_idx == IDX_W'(k))    regs_a[k] <= wr_data;
         end
      end else begin : g_ro
         assign regs_a[k] = DEFAULTS[8*k +: 8];
      end
      assign regs_flat[8*k +: 8] = regs_a[k];
   end

   always_comb begin
      rd_data = 8'h00;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (rd_idx == IDX_W'(i)) rd_data = regs_a[i];
      end
   end

   // R4: the controller never asks for a store beyond the last writable register
   a_r4_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (32'(wr_idx) <= WR_LAST));
endmodule

// File: rtl/cfgi2c_slave_fsm.sv
module cfgi2c_slave_fsm
   import cfgi2c_pkg::*;
#(
   parameter logic [6:0]  ADDR7    = 7'h69,
   parameter int unsigned NUM_REGS = 8,
   parameter int unsigned WR_LAST  = 6,
   parameter int unsigned IDX_W    = 3,
   parameter int unsigned BN_W     = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_lvl,
   input  logic             sda_lvl,
   input  logic             scl_rise,
   input  logic             scl_fall,
   input  logic             start_det,
   input  logic             stop_det,
   input  logic [7:0]       rd_data,
   output logic             wr_en,
   output logic [IDX_W-1:0] wr_idx,
   output logic [7:0]       wr_data,
   output logic [IDX_W-1:0] rd_idx,
   output logic             sda_pull
);
   localparam logic [7:0]      COUNT_BYTE = 8'(NUM_REGS);
   localparam logic [BN_W-1:0] BN_MAX     = '1;

   if ((2 ** BN_W) <= (NUM_REGS + HDR_BYTES + 1)) begin : g_bad_bn
      $error("cfgi2c_slave_fsm: BN_W too narrow for the register count");
   end

   slv_state_e      state;
   logic [2:0]      bitcnt;
   logic [7:0]      shreg;
   logic [BN_W-1:0] byte_no;
   logic            rw_q;
   logic            ack_on;
   logic            pull_q;

   logic [7:0]      rx_byte;
   logic [BN_W-1:0] bn_inc;
   logic [BN_W-1:0] data_pos;
   logic [BN_W-1:0] read_pos;
   logic            rd_ok;
   logic [7:0]      tx_byte;

   assign rx_byte  = {shreg[6:0], sda_lvl};
   assign bn_inc   = (byte_no == BN_MAX) ? byte_no : byte_no + 1'b1;
   assign data_pos = byte_no - BN_W'(HDR_BYTES);
   assign read_pos = byte_no - BN_W'(RD_SKIP);
   assign rd_ok    = (byte_no >= BN_W'(RD_SKIP)) && (read_pos < BN_W'(NUM_REGS));
   assign rd_idx   = read_pos[IDX_W-1:0];
   assign tx_byte  = (byte_no == BN_W'(1)) ? COUNT_BYTE : (rd_ok ? rd_data : 8'h00);

   assign wr_en   = (state == ST_RX) && scl_rise && (bitcnt == 3'd7) && !rw_q &&
                    !start_det && !stop_det &&
                    (byte_no >= BN_W'(HDR_BYTES)) && (data_pos <= BN_W'(WR_LAST));
   assign wr_idx  = data_pos[IDX_W-1:0];
   assign wr_data = rx_byte;
   assign sda_pull = pull_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         bitcnt  <= '0;
         shreg   <= '0;
         byte_no <= '0;
         rw_q    <= 1'b0;
         ack_on  <= 1'b0;
         pull_q  <= 1'b0;
      end else if (start_det) begin
         state   <= ST_RX;
         bitcnt  <= '0;
         byte_no <= '0;
         rw_q    <= 1'b0;
         ack_on  <= 1'b0;
         pull_q  <= 1'b0;
      end else if (stop_det) begin
         state   <= ST_IDLE;
         ack_on  <= 1'b0;
         pull_q  <= 1'b0;
      end else begin
         unique case (state)
            ST_RX: begin
               if (scl_rise) begin
                  shreg  <= rx_byte;
                  bitcnt <= bitcnt + 3'd1;
                  if (bitcnt == 3'd7) begin
                     ack_on  <= 1'b0;
                     byte_no <= bn_inc;
                     if (byte_no == '0) begin
                        if (rx_byte[7:1] == ADDR7) begin
                           rw_q  <= rx_byte[0];
                           state <= ST_RX_ACK;
                        end else begin
                           state <= ST_WAIT;
                        end
                     end else begin
                        state <= ST_RX_ACK;
                     end
                  end
               end
            end
            ST_RX_ACK: begin
               if (scl_fall) begin
                  if (!ack_on) begin
                     pull_q <= 1'b1;
                     ack_on <= 1'b1;
                  end else begin
                     ack_on <= 1'b0;
                     bitcnt <= '0;
                     if (rw_q) begin
                        shreg   <= tx_byte;
                        pull_q  <= ~tx_byte[7];
                        byte_no <= bn_inc;
                        state   <= ST_TX;
                     end else begin
                        pull_q <= 1'b0;
                        state  <= ST_RX;
                     end
                  end
               end
            end
            ST_TX: begin
               if (scl_fall) begin
                  if (bitcnt == 3'd7) begin
                     pull_q <= 1'b0;
                     state  <= ST_TX_ACK;
                  end else begin
                     shreg  <= {shreg[6:0], 1'b0};
                     pull_q <= ~shreg[6];
                     bitcnt <= bitcnt + 3'd1;
                  end
               end
            end
            ST_TX_ACK: begin
               if (scl_rise) state <= sda_lvl ? ST_WAIT : ST_TX_NEXT;
            end
            ST_TX_NEXT: begin
               if (scl_fall) begin
                  shreg   <= tx_byte;
                  pull_q  <= ~tx_byte[7];
                  bitcnt  <= '0;
                  byte_no <= bn_inc;
                  state   <= ST_TX;
               end
            end
            default: ;
         endcase
      end
   end

   // R10: a new low drive only ever starts in the low phase of SCL
   a_r10_drive_in_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pull_q) |-> !$past(scl_lvl));

   // R1: a non-matching address leaves the line alone
   a_r1_wait_is_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT) |-> !pull_q);

   // R7: a controller NACK on a read byte releases the line and parks the block
   a_r7_nack_releases: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_TX_ACK && scl_rise && sda_lvl && !start_det && !stop_det)
      |=> (state == ST_WAIT && !pull_q));

   // R8: every START rewinds the byte position
   a_r8_start_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (byte_no == '0 && state == ST_RX && !pull_q));

   // R2: header bytes never store into the bank
   a_r2_header_not_stored: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RX && byte_no < BN_W'(HDR_BYTES)) |-> !wr_en);
endmodule

// File: rtl/cfgi2c_slave_top.sv
module cfgi2c_slave_top
   import cfgi2c_pkg::*;
#(
   parameter logic [6:0]            ADDR7       = 7'h69,
   parameter int unsigned           NUM_REGS    = 8,
   parameter int unsigned           WR_LAST     = 6,
   parameter int unsigned           SYNC_STAGES = 2,
   parameter logic [NUM_REGS*8-1:0] DEFAULTS    = 64'h0000_0000_00FF_FF00
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  scl_i,
   input  logic                  sda_i,
   output logic                  sda_pull_o,
   output logic [NUM_REGS*8-1:0] regs_o
);
   localparam int unsigned IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
   localparam int unsigned BN_W  = $clog2(NUM_REGS + HDR_BYTES) + 1;

   if (NUM_REGS < 2 || NUM_REGS > 255) begin : g_bad_regs
      $error("cfgi2c_slave_top: NUM_REGS must lie in 2..255");
   end

   logic             scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
   logic             wr_en;
   logic [IDX_W-1:0] wr_idx, rd_idx;
   logic [7:0]       wr_data, rd_data;

   cfgi2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_lvl   (scl_lvl),
      .sda_lvl   (sda_lvl),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   cfgi2c_slave_fsm #(
      .ADDR7    (ADDR7),
      .NUM_REGS (NUM_REGS),
      .WR_LAST  (WR_LAST),
      .IDX_W    (IDX_W),
      .BN_W     (BN_W)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_lvl   (scl_lvl),
      .sda_lvl   (sda_lvl),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .rd_data   (rd_data),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .wr_data   (wr_data),
      .rd_idx    (rd_idx),
      .sda_pull  (sda_pull_o)
   );

   cfgi2c_reg_bank #(
      .NUM_REGS (NUM_REGS),
      .WR_LAST  (WR_LAST),
      .IDX_W    (IDX_W),
      .DEFAULTS (DEFAULTS)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .wr_data   (wr_data),
      .rd_idx    (rd_idx),
      .rd_data   (rd_data),
      .regs_flat (regs_o)
   );
endmodule

// File: tb/cfgi2c_slave_top_tb_top.sv
`timescale 1ns/1ps
module cfgi2c_slave_top_tb_top;
   localparam int Q = 10;   // clocks per quarter bit

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        m_scl = 1'b1;
   logic        m_sda = 1'b1;
   logic        sda_pull_o;
   logic [63:0] regs_o;
   logic        sda_line;

   int checks = 0;
   int failures = 0;
   int r10_viol = 0;
   bit done = 1'b0;
   logic [7:0] exp_regs [8];

   always #2.5 clk = ~clk;

   assign sda_line = m_sda & ~sda_pull_o;

   cfgi2c_slave_top dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (m_scl),
      .sda_i      (sda_line),
      .sda_pull_o (sda_pull_o),
      .regs_o     (regs_o)
   );

   logic prev_pull = 1'b0;
   logic prev_scl  = 1'b1;
   always @(negedge clk) begin
      if (rst_n && sda_pull_o && !prev_pull && m_scl && prev_scl) r10_viol++;
      prev_pull = sda_pull_o;
      prev_scl  = m_scl;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                      input string what);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   task automatic wq(input int n);
      repeat (n * Q) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda = 1'b1; wq(1);
      m_scl = 1'b1; wq(1);
      m_sda = 1'b0; wq(1);
      m_scl = 1'b0; wq(1);
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; wq(1);
      m_scl = 1'b1; wq(1);
      m_sda = 1'b1; wq(2);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic acked);
      for (int i = 7; i >= 0; i--) begin
         m_sda = b[i]; wq(1);
         m_scl = 1'b1; wq(2);
         m_scl = 1'b0; wq(1);
      end
      m_sda = 1'b1; wq(1);
      m_scl = 1'b1; wq(1);
      acked = ~sda_line;
      wq(1);
      m_scl = 1'b0; wq(1);
   endtask

   task automatic recv_byte(input logic give_ack, output logic [7:0] b);
      m_sda = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         wq(1);
         m_scl = 1'b1; wq(1);
         b[i] = sda_line;
         wq(1);
         m_scl = 1'b0; wq(1);
      end
      m_sda = ~give_ack; wq(1);
      m_scl = 1'b1; wq(2);
      m_scl = 1'b0; wq(1);
      m_sda = 1'b1;
   endtask

   task automatic check_regs(input string req, input string what);
      for (int k = 0; k < 8; k++) chk(req, 32'(regs_o[8*k +: 8]), 32'(exp_regs[k]), what);
   endtask

   task automatic t_reset();
      exp_regs = '{8'h00, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
      check_regs("R9", "reset value");
      chk("R9", 32'(sda_pull_o), 0, "SDA released after reset");
   endtask

   task automatic t_write_full();
      logic a;
      bus_start();
      send_byte(8'hD2, a); chk("R1", 32'(a), 1, "write address ack");
      send_byte(8'hA5, a); chk("R2", 32'(a), 1, "command byte ack");
      send_byte(8'h3C, a); chk("R2", 32'(a), 1, "count byte ack");
      for (int k = 0; k < 7; k++) begin
         send_byte(8'h10 + 8'(k), a); chk("R3", 32'(a), 1, "data byte ack");
         exp_regs[k] = 8'h10 + 8'(k);
      end
      send_byte(8'h77, a); chk("R4", 32'(a), 1, "surplus byte ack");
      send_byte(8'h88, a); chk("R4", 32'(a), 1, "second surplus byte ack");
      bus_stop();
      check_regs("R3", "sequential store");
      chk("R4", 32'(regs_o[63:56]), 32'h00, "read-only register 7 kept");
      chk("R2", 32'(regs_o[7:0]), 32'h10, "command byte not stored in reg0");
   endtask

   task automatic t_partial();
      logic a;
      bus_start();
      send_byte(8'hD2, a);
      send_byte(8'h00, a);
      send_byte(8'h02, a);
      send_byte(8'hC1, a);
      send_byte(8'hC2, a);
      bus_stop();
      exp_regs[0] = 8'hC1;
      exp_regs[1] = 8'hC2;
      check_regs("R5", "stop after two data bytes");
   endtask

   task automatic t_header_only();
      logic a;
      bus_start();
      send_byte(8'hD2, a);
      send_byte(8'hEE, a); chk("R2", 32'(a), 1, "command ack, header-only write");
      send_byte(8'hDD, a); chk("R2", 32'(a), 1, "count ack, header-only write");
      bus_stop();
      check_regs("R2", "header-only write leaves bank");
   endtask

   task automatic t_read_all();
      logic a;
      logic [7:0] b;
      bus_start();
      send_byte(8'hD3, a); chk("R1", 32'(a), 1, "read address ack");
      recv_byte(1'b1, b);  chk("R6", 32'(b), 32'h08, "count byte");
      for (int k = 0; k < 8; k++) begin
         recv_byte(k != 7, b);
         chk("R6", 32'(b), 32'(exp_regs[k]), "register read-back");
      end
      bus_stop();
      chk("R7", 32'(sda_pull_o), 0, "released after final NACK");
   endtask

   task automatic t_bad_addr();
      logic a;
      bus_start();
      send_byte(8'hA0, a); chk("R1", 32'(a), 0, "foreign address not acked");
      send_byte(8'h00, a); chk("R1", 32'(a), 0, "byte after foreign address not acked");
      send_byte(8'h55, a); chk("R1", 32'(a), 0, "second byte after foreign address");
      bus_stop();
      check_regs("R1", "foreign transfer leaves bank");
   endtask

   task automatic t_early_nack();
      logic a;
      logic [7:0] b;
      bus_start();
      send_byte(8'hD3, a);
      recv_byte(1'b0, b); chk("R6", 32'(b), 32'h08, "count before NACK");
      recv_byte(1'b0, b); chk("R7", 32'(b), 32'hFF, "line idle after NACK");
      bus_stop();
   endtask

   task automatic t_restart();
      logic a;
      logic [7:0] b;
      bus_start();
      send_byte(8'hD2, a);
      send_byte(8'h00, a);
      send_byte(8'h00, a);
      send_byte(8'hE0, a);
      send_byte(8'hE9, a);
      bus_start();
      send_byte(8'hD2, a); chk("R8", 32'(a), 1, "address after repeated START");
      send_byte(8'h00, a);
      send_byte(8'h00, a);
      send_byte(8'hE1, a);
      bus_stop();
      exp_regs[0] = 8'hE1;
      exp_regs[1] = 8'hE9;
      check_regs("R8", "pointer rewound by repeated START");
      bus_start();
      send_byte(8'hD3, a);
      recv_byte(1'b1, b);
      recv_byte(1'b0, b); chk("R8", 32'(b), 32'hE1, "first read reg0");
      bus_start();
      send_byte(8'hD3, a);
      recv_byte(1'b0, b); chk("R8", 32'(b), 32'h08, "count again after repeated START");
      bus_stop();
   endtask

   initial begin
      repeat (10) @(negedge clk);
      rst_n = 1'b1;
      repeat (10) @(negedge clk);
      t_reset();
      t_header_only();
      t_write_full();
      t_partial();
      t_read_all();
      t_bad_addr();
      t_early_nack();
      t_restart();
      chk("R10", 32'(r10_viol), 0, "pull asserted while SCL high");
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule